// File: doc/BRIEF.md
# Compact 16-bit Multicycle Processor Core

This core runs a small program held in an external instruction memory. Each instruction is 16 bits wide. Each one passes through a fetch step, a decode step and an execute step. The core has eight 16-bit general registers and a 16-bit program counter that counts instructions, not bytes. It can add registers. It builds constants with two byte-wide immediate moves, each of which keeps the other byte of the register. It loads and stores words at a base register plus a signed offset. It has an absolute jump, a register-relative jump and a branch taken when two registers are equal. A software trap hands a register index and an immediate to an outside agent and waits until that agent reports completion.

The core never traps on an error. It stops by itself in three cases: an undefined opcode, a jump or branch target beyond the loaded program, and the fetch of the last instruction of the program. In the last case that instruction still completes. After a stop, the core does nothing until reset. A system supplies the program length in bytes and watches `halted` to learn when the run is over.

Top module: `core16`

## Requirements
- R1: After reset the program counter, all eight registers and the halt flag are zero, `halted` is 0, the first fetch reads byte address 0, and a register never written reads as 0.
- R2: `iAddr` is the program counter times 2. Instructions run in order. The fields are: opcode in bits 15:12, rs in bits 11:9, ra in bits 8:6, rb in bits 5:3, imm in bits 7:0, signed offset in bits 5:0, jump address in bits 11:0. Opcode 0 does nothing.
- R3: Opcode 1 writes ra + rb into rs, wrapping modulo 2^16.
- R4: Opcode 2 replaces bits 7:0 of rs with imm and keeps bits 15:8. Opcode 3 replaces bits 15:8 of rs with imm and keeps bits 7:0.
- R5: Opcode 4 holds `dRead` high with `dAddr` = ra + offset and keeps the address stable until `dValid`. It then writes `dRdData` into rs.
- R6: Opcode 5 raises `dWrite` for exactly one cycle, with `dAddr` = rs + offset and `dWrData` = ra. `dRead` and `dWrite` are never high together.
- R7: Opcode 6 sets the program counter to the jump address field. Opcode 7 sets it to rs + imm, with imm zero-extended.
- R8: Opcode 8 adds the offset to the already-incremented program counter when rs equals ra. Otherwise it continues with the next instruction. Backward offsets are allowed.
- R9: A jump or taken branch whose target is greater than `progLen`/2 sets the halt flag and leaves the program counter unchanged. A target equal to `progLen`/2 is accepted.
- R10: A fetch for which PC+1 >= `progLen`/2 sets `halted`, yet that instruction still executes completely.
- R11: Opcodes 10 through 15 set the halt flag and have no other effect.
- R12: Opcode 9 raises `trapReq` for one cycle, with `trapIdx` = bits 11:9 and `trapImm` = bits 7:0. No further fetch happens until `trapDone` is seen.
- R13: Once set, `halted` stays 1 until reset. After the stopping instruction finishes there is no fetch progress, no memory access and no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| progLen | input | 16 | Loaded program length in bytes (even) |
| iAddr | output | 16 | Instruction byte address |
| iData | input | 16 | Instruction word at `iAddr`, same cycle |
| dAddr | output | 16 | Data memory address |
| dWrData | output | 16 | Store data |
| dRdData | input | 16 | Load data, valid with `dValid` |
| dRead | output | 1 | Load request, held until `dValid` |
| dWrite | output | 1 | One-cycle store strobe |
| dValid | input | 1 | Load data ready |
| trapReq | output | 1 | One-cycle software trap strobe |
| trapIdx | output | 3 | Register index carried by the trap |
| trapImm | output | 8 | Immediate carried by the trap |
| trapDone | input | 1 | Trap service finished |
| halted | output | 1 | Core has stopped |

## Verification
The byte moves are tried in sequences that write the same register twice with different byte lanes. Only a true merge keeps the earlier byte, so these sequences catch a move that clears the other half. Additions with all-ones operands expose missing wrap-around, and loads with a negative offset and a three-cycle latency separate held requests from single pulses. Control flow is tried with a forward jump, a taken and an untaken branch, a register jump and a backward branch, each over stores that must not appear in the store log. Targets one past the limit and exactly at the limit, undefined opcodes, the final instruction and a trap with delayed completion then tell the three stop conditions apart from ordinary flow.

// File: rtl/core16_pkg.sv
package core16_pkg;
  localparam int XLEN    = 16;
  localparam int OPC_W   = 4;
  localparam int RIDX_W  = 3;
  localparam int NREGS   = 1 << RIDX_W;
  localparam int IMM_W   = 8;
  localparam int OFF_W   = 6;
  localparam int JADDR_W = 12;
  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int RS_LSB  = OPC_LSB - RIDX_W;
  localparam int RA_LSB  = RS_LSB - RIDX_W;
  localparam int RB_LSB  = RA_LSB - RIDX_W;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_MOVL  = 4'd2,
    OP_MOVH  = 4'd3,
    OP_LOAD  = 4'd4,
    OP_STORE = 4'd5,
    OP_JMP   = 4'd6,
    OP_JREG  = 4'd7,
    OP_BEQ   = 4'd8,
    OP_TRAP  = 4'd9
  } opcode_e;

  typedef enum logic [1:0] {
    WB_SUM    = 2'd0,
    WB_LOBYTE = 2'd1,
    WB_HIBYTE = 2'd2,
    WB_MEM    = 2'd3
  } wbSel_e;

  typedef struct packed {
    logic   irLoad;
    logic   opLatch;
    logic   regWr;
    wbSel_e wbSel;
    logic   pcLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/core16_datapath.sv
module core16_datapath
  import core16_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     ctrl,
  input  logic [XLEN-1:0] progLen,
  input  logic [XLEN-1:0] iData,
  input  logic [XLEN-1:0] dRdData,
  output logic [XLEN-1:0] iAddr,
  output logic [XLEN-1:0] dAddr,
  output logic [XLEN-1:0] dWrData,
  output opcode_e         opcode,
  output logic            atEnd,
  output logic            targetOob,
  output logic            opsEqual,
  output logic [RIDX_W-1:0] trapIdx,
  output logic [IMM_W-1:0]  trapImm
);
  logic [XLEN-1:0] pcQ, irQ, aQ, bQ, cQ, addrQ;
  logic [XLEN-1:0] rf [NREGS];
  logic [RIDX_W-1:0] rsIdx, raIdx, rbIdx;
  logic [IMM_W-1:0]  immF;
  logic [XLEN-1:0]   offExt, immExt, target, wbData, halfLen, baseSel;

  // instruction field split
  assign rsIdx  = irQ[RS_LSB +: RIDX_W];
  assign raIdx  = irQ[RA_LSB +: RIDX_W];
  assign rbIdx  = irQ[RB_LSB +: RIDX_W];
  assign immF   = irQ[IMM_W-1:0];
  assign offExt = {{(XLEN-OFF_W){irQ[OFF_W-1]}}, irQ[OFF_W-1:0]};
  assign immExt = {{(XLEN-IMM_W){1'b0}}, immF};
  assign opcode = opcode_e'(irQ[OPC_LSB +: OPC_W]);

  assign halfLen = progLen >> 1;
  assign iAddr   = pcQ << 1;
  assign dAddr   = addrQ;
  assign dWrData = bQ;
  assign trapIdx = rsIdx;
  assign trapImm = immF;

  // end-of-program test uses the not yet incremented counter
  assign atEnd = ({1'b0, pcQ} + {{XLEN{1'b0}}, 1'b1}) >= {1'b0, halfLen};

  always_comb begin
    case (opcode)
      OP_JMP:  target = {{(XLEN-JADDR_W){1'b0}}, irQ[JADDR_W-1:0]};
      OP_JREG: target = aQ + immExt;
      default: target = pcQ + offExt;
    endcase
  end

  assign targetOob = target > halfLen;
  assign opsEqual  = (aQ == bQ);

  always_comb begin
    case (ctrl.wbSel)
      WB_SUM:    wbData = bQ + cQ;
      WB_LOBYTE: wbData = {aQ[XLEN-1:IMM_W], immF};
      WB_HIBYTE: wbData = {immF, aQ[XLEN-IMM_W-1:0]};
      default:   wbData = dRdData;
    endcase
  end

  // store uses rs as base, load uses ra as base
  assign baseSel = (opcode == OP_STORE) ? rf[rsIdx] : rf[raIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ   <= '0;
      irQ   <= '0;
      aQ    <= '0;
      bQ    <= '0;
      cQ    <= '0;
      addrQ <= '0;
    end else begin
      if (ctrl.irLoad) begin
        irQ <= iData;
        pcQ <= pcQ + XLEN'(1);
      end else if (ctrl.pcLoad) begin
        pcQ <= target;
      end
      if (ctrl.opLatch) begin
        aQ    <= rf[rsIdx];
        bQ    <= rf[raIdx];
        cQ    <= rf[rbIdx];
        addrQ <= baseSel + offExt;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (ctrl.regWr) begin
      rf[rsIdx] <= wbData;
    end
  end

  // R2
  fetch_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.irLoad |=> pcQ == $past(pcQ) + XLEN'(1));

  // R4
  lobyte_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.regWr && ctrl.wbSel == WB_LOBYTE) |=>
      rf[rsIdx][XLEN-1:IMM_W] == $past(rf[rsIdx][XLEN-1:IMM_W]));

  // R9
  oob_nojump_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcLoad |-> !targetOob);
endmodule

// File: rtl/core16_control.sv
module core16_control
  import core16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  opcode_e     opcode,
  input  logic        atEnd,
  input  logic        targetOob,
  input  logic        opsEqual,
  input  logic        dValid,
  input  logic        trapDone,
  output ctrlStrobe_t ctrl,
  output logic        dRead,
  output logic        dWrite,
  output logic        trapReq,
  output logic        halted
);
  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_LOADWAIT, S_TRAPWAIT, S_HALT
  } state_e;

  state_e stateQ, nextState;
  logic   haltQ, haltSet;

  assign halted = haltQ;

  always_comb begin
    ctrl      = '0;
    nextState = stateQ;
    haltSet   = 1'b0;
    dRead     = 1'b0;
    dWrite    = 1'b0;
    trapReq   = 1'b0;
    case (stateQ)
      S_FETCH: begin
        ctrl.irLoad = 1'b1;
        haltSet     = atEnd;
        nextState   = S_DECODE;
      end
      S_DECODE: begin
        ctrl.opLatch = 1'b1;
        nextState    = S_EXEC;
      end
      S_EXEC: begin
        nextState = S_FETCH;
        case (opcode)
          OP_NOP: ;
          OP_ADD: begin
            ctrl.regWr = 1'b1;
            ctrl.wbSel = WB_SUM;
          end
          OP_MOVL: begin
            ctrl.regWr = 1'b1;
            ctrl.wbSel = WB_LOBYTE;
          end
          OP_MOVH: begin
            ctrl.regWr = 1'b1;
            ctrl.wbSel = WB_HIBYTE;
          end
          OP_LOAD:  nextState = S_LOADWAIT;
          OP_STORE: dWrite = 1'b1;
          OP_JMP, OP_JREG: begin
            if (targetOob) haltSet = 1'b1;
            else           ctrl.pcLoad = 1'b1;
          end
          OP_BEQ: begin
            if (opsEqual) begin
              if (targetOob) haltSet = 1'b1;
              else           ctrl.pcLoad = 1'b1;
            end
          end
          OP_TRAP: begin
            trapReq   = 1'b1;
            nextState = S_TRAPWAIT;
          end
          default: haltSet = 1'b1;
        endcase
        if (nextState == S_FETCH && (haltQ || haltSet)) nextState = S_HALT;
      end
      S_LOADWAIT: begin
        dRead = 1'b1;
        if (dValid) begin
          ctrl.regWr = 1'b1;
          ctrl.wbSel = WB_MEM;
          nextState  = haltQ ? S_HALT : S_FETCH;
        end
      end
      S_TRAPWAIT: begin
        if (trapDone) nextState = haltQ ? S_HALT : S_FETCH;
      end
      S_HALT: ;
      default: nextState = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_FETCH;
      haltQ  <= 1'b0;
    end else begin
      stateQ <= nextState;
      haltQ  <= haltQ | haltSet;
    end
  end

  // R13
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |=> haltQ);

  // R12
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> !trapReq);
endmodule

// File: rtl/core16.sv
module core16
  import core16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] progLen,
  output logic [15:0] iAddr,
  input  logic [15:0] iData,
  output logic [15:0] dAddr,
  output logic [15:0] dWrData,
  input  logic [15:0] dRdData,
  output logic        dRead,
  output logic        dWrite,
  input  logic        dValid,
  output logic        trapReq,
  output logic [2:0]  trapIdx,
  output logic [7:0]  trapImm,
  input  logic        trapDone,
  output logic        halted
);
  ctrlStrobe_t ctrl;
  opcode_e     opcode;
  logic        atEnd, targetOob, opsEqual;

  core16_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .progLen   (progLen),
    .iData     (iData),
    .dRdData   (dRdData),
    .iAddr     (iAddr),
    .dAddr     (dAddr),
    .dWrData   (dWrData),
    .opcode    (opcode),
    .atEnd     (atEnd),
    .targetOob (targetOob),
    .opsEqual  (opsEqual),
    .trapIdx   (trapIdx),
    .trapImm   (trapImm)
  );

  core16_control uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .opcode    (opcode),
    .atEnd     (atEnd),
    .targetOob (targetOob),
    .opsEqual  (opsEqual),
    .dValid    (dValid),
    .trapDone  (trapDone),
    .ctrl      (ctrl),
    .dRead     (dRead),
    .dWrite    (dWrite),
    .trapReq   (trapReq),
    .halted    (halted)
  );

  // R5
  load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dRead && !dValid) |=> dRead && $stable(dAddr));

  // R6
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dRead && dWrite));
endmodule

// File: tb/sim_core16.sv
`timescale 1ns/1ps
module sim_core16;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] progLen = 16'd0;
  logic [15:0] iAddr, iData, dAddr, dWrData;
  logic [15:0] dRdData;
  logic        dRead, dWrite, dValid;
  logic        trapReq, trapDone, halted;
  logic [2:0]  trapIdx;
  logic [7:0]  trapImm;

  logic [15:0] imem [0:63];
  assign iData = imem[iAddr[6:1]];

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  core16 u0 (
    .clk(clk), .rstN(rstN), .progLen(progLen), .iAddr(iAddr), .iData(iData),
    .dAddr(dAddr), .dWrData(dWrData), .dRdData(dRdData), .dRead(dRead),
    .dWrite(dWrite), .dValid(dValid), .trapReq(trapReq), .trapIdx(trapIdx),
    .trapImm(trapImm), .trapDone(trapDone), .halted(halted)
  );

  // ---------------- environment monitors (sampled at negedge) ------------
  logic [15:0] logAddr [0:15];
  logic [15:0] logData [0:15];
  logic        logHalt [0:15];
  int          logCnt;
  int          ldCnt, ldCycles;
  logic [15:0] ldAddrSeen;
  logic        prevRead;
  int          ldWait;
  int          trapCnt, trapWait;
  logic [2:0]  trapIdxSeen;
  logic [7:0]  trapImmSeen;
  logic [15:0] trapPc;
  logic        trapLong, trapMoved, prevTrap;

  always @(negedge clk) begin
    if (!rstN) begin
      logCnt <= 0; ldCnt <= 0; ldCycles <= 0; ldAddrSeen <= '0; prevRead <= 1'b0;
      ldWait <= 0; dValid <= 1'b0; dRdData <= '0;
      trapCnt <= 0; trapWait <= 0; trapIdxSeen <= '0; trapImmSeen <= '0;
      trapPc <= '0; trapLong <= 1'b0; trapMoved <= 1'b0; prevTrap <= 1'b0;
      trapDone <= 1'b0;
    end else begin
      if (dWrite && logCnt < 16) begin
        logAddr[logCnt] <= dAddr;
        logData[logCnt] <= dWrData;
        logHalt[logCnt] <= halted;
        logCnt <= logCnt + 1;
      end
      prevRead <= dRead;
      if (dRead && !prevRead) begin
        ldCnt <= ldCnt + 1;
        ldAddrSeen <= dAddr;
      end
      if (dRead) ldCycles <= ldCycles + 1;
      if (dRead && !dValid) begin
        if (ldWait == LAT - 1) begin
          dValid  <= 1'b1;
          dRdData <= dAddr ^ 16'hA5A5;
          ldWait  <= 0;
        end else ldWait <= ldWait + 1;
      end else dValid <= 1'b0;

      prevTrap <= trapReq;
      if (trapReq && prevTrap) trapLong <= 1'b1;
      if (trapReq) begin
        trapCnt <= trapCnt + 1;
        trapIdxSeen <= trapIdx;
        trapImmSeen <= trapImm;
        trapPc <= iAddr;
        trapWait <= 4;
      end else if (trapWait > 0) begin
        trapWait <= trapWait - 1;
        if (iAddr != trapPc) trapMoved <= 1'b1;
      end
      trapDone <= (trapWait == 1) && !trapReq;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [15:0] encR(input logic [3:0] op, input logic [2:0] rs,
                                       input logic [2:0] ra, input logic [2:0] rb);
    return {op, rs, ra, rb, 3'b000};
  endfunction
  function automatic logic [15:0] encI(input logic [3:0] op, input logic [2:0] rs,
                                       input logic [7:0] imm);
    return {op, rs, 1'b0, imm};
  endfunction
  function automatic logic [15:0] encM(input logic [3:0] op, input logic [2:0] rs,
                                       input logic [2:0] ra, input logic [5:0] off);
    return {op, rs, ra, off};
  endfunction
  function automatic logic [15:0] encJ(input logic [3:0] op, input logic [11:0] addr);
    return {op, addr};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) imem[i] = 16'h0000;
  endtask

  task automatic runProg(input int n);
    rstN = 1'b0;
    progLen = 16'(n * 2);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic checkLog(input string req, input int idx,
                          input logic [15:0] a, input logic [15:0] d);
    check(req, $sformatf("store %0d addr", idx), logAddr[idx], a);
    check(req, $sformatf("store %0d data", idx), logData[idx], d);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    clearMem();
    imem[0] = encM(4'd5, 3'd0, 3'd5, 6'd10);   // store untouched r5 to 10
    rstN = 1'b0;
    progLen = 16'd2;
    repeat (2) @(negedge clk);
    check("R1", "halted in reset", {15'd0, halted}, 16'd0);
    check("R1", "strobes in reset", {13'd0, dRead, dWrite, trapReq}, 16'd0);
    rstN = 1'b1;
    #1;
    check("R1", "first fetch address", iAddr, 16'h0000);
    for (int i = 0; i < 100 && !halted; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    check("R1", "store count", 16'(logCnt), 16'd1);
    checkLog("R1", 0, 16'd10, 16'h0000);
  endtask

  task automatic testArith();
    clearMem();
    imem[0]  = encI(4'd2, 3'd1, 8'h34);
    imem[1]  = encI(4'd3, 3'd1, 8'h12);
    imem[2]  = encI(4'd2, 3'd1, 8'hAB);
    imem[3]  = encM(4'd5, 3'd0, 3'd1, 6'd1);
    imem[4]  = encI(4'd3, 3'd2, 8'hFF);
    imem[5]  = encI(4'd2, 3'd2, 8'hFF);
    imem[6]  = encI(4'd2, 3'd3, 8'h02);
    imem[7]  = encR(4'd1, 3'd4, 3'd2, 3'd3);
    imem[8]  = encM(4'd5, 3'd0, 3'd4, 6'd2);
    imem[9]  = encR(4'd1, 3'd5, 3'd1, 3'd1);
    imem[10] = encM(4'd5, 3'd0, 3'd5, 6'd3);
    imem[11] = encM(4'd5, 3'd0, 3'd2, 6'd4);
    imem[12] = 16'h0000;
    runProg(13);
    check("R2", "store count", 16'(logCnt), 16'd4);
    checkLog("R4", 0, 16'd1, 16'h12AB);
    checkLog("R3", 1, 16'd2, 16'h0001);
    checkLog("R3", 2, 16'd3, 16'h2556);
    checkLog("R4", 3, 16'd4, 16'hFFFF);
  endtask

  task automatic testLoad();
    clearMem();
    imem[0] = encI(4'd2, 3'd1, 8'h10);
    imem[1] = encM(4'd4, 3'd2, 3'd1, 6'h3E);   // offset -2
    imem[2] = encI(4'd2, 3'd3, 8'h20);
    imem[3] = encM(4'd5, 3'd3, 3'd2, 6'd0);
    imem[4] = encM(4'd5, 3'd3, 3'd2, 6'h3F);   // offset -1
    runProg(5);
    check("R5", "load requests", 16'(ldCnt), 16'd1);
    check("R5", "load address", ldAddrSeen, 16'h000E);
    check("R5", "read held cycles", 16'(ldCycles), 16'(LAT));
    check("R6", "store count", 16'(logCnt), 16'd2);
    checkLog("R5", 0, 16'h0020, 16'hA5AB);
    checkLog("R6", 1, 16'h001F, 16'hA5AB);
  endtask

  task automatic testFlow();
    clearMem();
    imem[0]  = encI(4'd2, 3'd1, 8'd5);
    imem[1]  = encI(4'd2, 3'd2, 8'd5);
    imem[2]  = encJ(4'd6, 12'd4);
    imem[3]  = encM(4'd5, 3'd0, 3'd1, 6'd20);
    imem[4]  = encM(4'd8, 3'd1, 3'd2, 6'd2);    // equal: to 7
    imem[5]  = encM(4'd5, 3'd0, 3'd1, 6'd21);
    imem[6]  = encM(4'd5, 3'd0, 3'd1, 6'd22);
    imem[7]  = encI(4'd2, 3'd3, 8'd6);
    imem[8]  = encM(4'd8, 3'd1, 3'd3, 6'd1);    // not equal
    imem[9]  = encM(4'd5, 3'd0, 3'd1, 6'd23);
    imem[10] = encI(4'd2, 3'd4, 8'd10);
    imem[11] = encI(4'd7, 3'd4, 8'd3);          // to 13
    imem[12] = encM(4'd5, 3'd0, 3'd1, 6'd24);
    imem[13] = encM(4'd5, 3'd0, 3'd3, 6'd25);
    imem[14] = encJ(4'd6, 12'd17);
    imem[15] = encM(4'd5, 3'd0, 3'd4, 6'd26);
    imem[16] = encJ(4'd6, 12'd18);
    imem[17] = encM(4'd8, 3'd0, 3'd0, 6'h3D);   // back to 15
    imem[18] = 16'h0000;
    runProg(19);
    check("R7", "store count", 16'(logCnt), 16'd3);
    checkLog("R8", 0, 16'd23, 16'd5);
    checkLog("R7", 1, 16'd25, 16'd6);
    checkLog("R8", 2, 16'd26, 16'd10);
  endtask

  task automatic testOob();
    clearMem();
    imem[0] = encI(4'd2, 3'd1, 8'd7);
    imem[1] = encJ(4'd6, 12'd5);                // 5 > 4: stop
    imem[2] = encM(4'd5, 3'd0, 3'd1, 6'd1);
    imem[3] = encM(4'd5, 3'd0, 3'd1, 6'd2);
    runProg(4);
    check("R9", "halted", {15'd0, halted}, 16'd1);
    check("R9", "no store after stop", 16'(logCnt), 16'd0);
    check("R9", "pc kept", iAddr, 16'd4);
    // exactly at the limit is accepted
    clearMem();
    imem[0] = encI(4'd2, 3'd1, 8'd9);
    imem[1] = encJ(4'd6, 12'd3);                // 3 == 6/2
    imem[2] = encM(4'd5, 3'd0, 3'd1, 6'd1);
    imem[3] = encM(4'd5, 3'd0, 3'd1, 6'd2);
    runProg(3);
    check("R9", "limit target store count", 16'(logCnt), 16'd1);
    checkLog("R9", 0, 16'd2, 16'd9);
    check("R10", "pc after limit fetch", iAddr, 16'd8);
  endtask

  task automatic testIllegal(input logic [3:0] op);
    clearMem();
    imem[0] = encI(4'd2, 3'd1, 8'd3);
    imem[1] = {op, 12'h123};
    imem[2] = encM(4'd5, 3'd0, 3'd1, 6'd1);
    runProg(3);
    check("R11", $sformatf("halted op %0d", op), {15'd0, halted}, 16'd1);
    check("R11", $sformatf("no store op %0d", op), 16'(logCnt), 16'd0);
    check("R11", $sformatf("pc op %0d", op), iAddr, 16'd4);
  endtask

  task automatic testEnd();
    logic [15:0] pcAtHalt;
    int          cntAtHalt;
    clearMem();
    imem[0] = encI(4'd2, 3'd1, 8'h77);
    imem[1] = encM(4'd5, 3'd0, 3'd1, 6'd9);
    imem[2] = encM(4'd5, 3'd0, 3'd1, 6'd10);
    runProg(2);
    check("R10", "store count", 16'(logCnt), 16'd1);
    checkLog("R10", 0, 16'd9, 16'h0077);
    check("R10", "halted during last", {15'd0, logHalt[0]}, 16'd1);
    pcAtHalt  = iAddr;
    cntAtHalt = logCnt;
    repeat (30) @(negedge clk);
    check("R13", "halted sticky", {15'd0, halted}, 16'd1);
    check("R13", "fetch frozen", iAddr, pcAtHalt);
    check("R13", "no more stores", 16'(logCnt), 16'(cntAtHalt));
    check("R13", "no trap", 16'(trapCnt), 16'd0);
  endtask

  task automatic testTrap();
    clearMem();
    imem[0] = encI(4'd2, 3'd1, 8'h41);
    imem[1] = encI(4'd9, 3'd5, 8'h3C);
    imem[2] = encM(4'd5, 3'd0, 3'd1, 6'd12);
    runProg(3);
    check("R12", "trap count", 16'(trapCnt), 16'd1);
    check("R12", "trap index", {13'd0, trapIdxSeen}, 16'd5);
    check("R12", "trap imm", {8'd0, trapImmSeen}, 16'h003C);
    check("R12", "trap one cycle", {15'd0, trapLong}, 16'd0);
    check("R12", "no fetch while waiting", {15'd0, trapMoved}, 16'd0);
    check("R12", "resumes after done", 16'(logCnt), 16'd1);
    checkLog("R12", 0, 16'd12, 16'h0041);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testArith();
    testLoad();
    testFlow();
    testOob();
    testIllegal(4'hF);
    testIllegal(4'hA);
    testEnd();
    testTrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule